// File: doc/BRIEF.md
# Descriptor Ring Address Sequencer

This block walks a circular ring of DMA descriptors and gives the byte address of the descriptor that is current. Software sets the ring's base address, the descriptor-size mode and a compact length code, all captured with one load command. The length code is log-encoded, and its width depends on the mode. After that, a ring length that the code cannot express may be written directly, and it replaces the decoded length. Each `advance` pulse moves to the next entry. When the sequencer steps past the last entry it returns to entry 0 and raises a wrap flag for one cycle.

One instance serves one ring, and a parent places one for transmit and one for receive. Position tracking is a small state machine with three states. `POS_HEAD` means the current index is 0. `POS_BODY` means the index lies strictly between the first and last entries. `POS_TAIL` means the index is length−1 and the length is greater than 1. The transitions are as follows:
- HEAD→HEAD on an advance with a one-entry ring, with wrap.
- HEAD→TAIL on an advance with a two-entry ring.
- HEAD→BODY on an advance with a longer ring.
- BODY→BODY on an advance that does not reach the last entry.
- BODY→TAIL on an advance onto the last entry.
- TAIL→HEAD on an advance, with wrap.
- Any state→HEAD on a load, an explicit length write or a restart.

Top module: `ring_desc_seq`

## Requirements
- R1: With `mode32`=1 the 4-bit `len_code` values 0 to 9 give rings of 2^code entries (1 to 512).
- R2: With `mode32`=1 every `len_code` value from 10 to 15 gives a 512-entry ring.
- R3: With `mode32`=0 only `len_code[2:0]` is used and gives 2^code entries (1 to 128). `len_code[3]` has no effect.
- R4: `entry_addr` = base + `entry_idx`×16 when the loaded mode is 32-bit, and base + `entry_idx`×8 otherwise.
- R5: On load, base address bits [3:0] are cleared in 32-bit mode and bits [2:0] in 16-bit mode.
- R6: A `len_wr` pulse replaces the ring length with `len_val`, including lengths the code cannot express. In the same cycle it takes priority over the length from `load`.
- R7: A `len_wr` with `len_val`=0 gives a one-entry ring. The index stays 0 and every advance wraps.
- R8: `advance` increments `entry_idx`. An advance at index length−1 sets it to 0, and `entry_wrap` is high in exactly the cycle after that advance.
- R9: `restart`, `load` and `len_wr` each set `entry_idx` to 0 and take priority over an `advance` in the same cycle, with no wrap.
- R10: After reset `entry_idx`=0, `entry_wrap`=0, `entry_addr`=0 and the ring has one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Capture base, mode and length code |
| base_addr | input | AW | Ring base byte address |
| mode32 | input | 1 | 1: 16-byte descriptors, 4-bit code; 0: 8-byte, 3-bit code |
| len_code | input | 4 | Log-encoded ring length |
| len_wr | input | 1 | Write explicit ring length |
| len_val | input | LW | Explicit ring length (0 treated as 1) |
| restart | input | 1 | Return to entry 0 |
| advance | input | 1 | Step to the next entry |
| entry_idx | output | LW | Current entry index |
| entry_addr | output | AW | Byte address of current entry |
| entry_wrap | output | 1 | One-cycle pulse after wrapping to entry 0 |

## Verification
The length decoder is driven from a table of mode and code pairs. The pairs cover both ends of the 32-bit range, the saturating codes 10, 12 and 15, and the 16-bit range with bit 3 both clear and set. For each pair, a full walk around the ring must show no early wrap and exactly one wrap at the decoded length. Together these separate a wrong exponent, missing saturation, and a leak of bit 3 in 16-bit mode. Directed sequences then separate the two strides and the two base masks. They also show an explicit length of 5, which no code can express, overriding the code, and a zero length acting as one entry. Finally they check that restart, load and length writes each take priority over a simultaneous advance.

// File: rtl/ring_seq_pkg.sv
package ring_seq_pkg;
    typedef enum logic [1:0] {
        POS_HEAD = 2'd0,
        POS_BODY = 2'd1,
        POS_TAIL = 2'd2
    } ring_pos_e;

    localparam int SHIFT_WIDE   = 4;   // 16-byte descriptor slot
    localparam int SHIFT_NARROW = 3;   // 8-byte descriptor slot
    localparam int MAX_EXP_WIDE = 9;   // 512 entries
endpackage

// File: rtl/ring_len_decode.sv
module ring_len_decode
    import ring_seq_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic          mode32,
    input  logic [3:0]    len_code,
    output logic [LW-1:0] dec_len
);
    logic [3:0] expo;

    always_comb begin
        if (mode32) begin
            expo = (len_code > 4'(MAX_EXP_WIDE)) ? 4'(MAX_EXP_WIDE) : len_code;
        end else begin
            expo = {1'b0, len_code[2:0]};
        end
        dec_len = LW'(1) << expo;
    end
endmodule

// File: rtl/ring_cfg_store.sv
module ring_cfg_store
    import ring_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base_addr,
    input  logic          mode32,
    input  logic [LW-1:0] dec_len,
    input  logic          len_wr,
    input  logic [LW-1:0] len_val,
    output logic [AW-1:0] base_q,
    output logic          mode_q,
    output logic [LW-1:0] len_q
);
    logic [AW-1:0] base_masked;

    always_comb begin
        base_masked = base_addr;
        if (mode32) begin
            base_masked[SHIFT_WIDE-1:0] = '0;
        end else begin
            base_masked[SHIFT_NARROW-1:0] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            mode_q <= 1'b0;
            len_q  <= LW'(1);
        end else begin
            if (load) begin
                base_q <= base_masked;
                mode_q <= mode32;
                len_q  <= dec_len;
            end
            if (len_wr) begin
                len_q <= (len_val == '0) ? LW'(1) : len_val;
            end
        end
    end
endmodule

// File: rtl/ring_addr_calc.sv
module ring_addr_calc
    import ring_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic [AW-1:0] base_q,
    input  logic          mode_q,
    input  logic [LW-1:0] idx,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] offset;

    always_comb begin
        if (mode_q) begin
            offset = AW'(idx) << SHIFT_WIDE;
        end else begin
            offset = AW'(idx) << SHIFT_NARROW;
        end
        addr = base_q + offset;
    end
endmodule

// File: rtl/ring_desc_seq.sv
module ring_desc_seq
    import ring_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base_addr,
    input  logic          mode32,
    input  logic [3:0]    len_code,
    input  logic          len_wr,
    input  logic [LW-1:0] len_val,
    input  logic          restart,
    input  logic          advance,
    output logic [LW-1:0] entry_idx,
    output logic [AW-1:0] entry_addr,
    output logic          entry_wrap
);
    logic [LW-1:0] dec_len;
    logic [AW-1:0] base_q;
    logic          mode_q;
    logic [LW-1:0] len_q;

    ring_pos_e     pos_q, pos_d;
    logic [LW-1:0] idx_q, idx_d;
    logic          wrap_q, wrap_d;
    logic          rewind;
    logic [LW:0]   idx_plus2;

    ring_len_decode #(.LW(LW)) u_dec (
        .mode32   (mode32),
        .len_code (len_code),
        .dec_len  (dec_len)
    );

    ring_cfg_store #(.AW(AW), .LW(LW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .base_addr (base_addr),
        .mode32    (mode32),
        .dec_len   (dec_len),
        .len_wr    (len_wr),
        .len_val   (len_val),
        .base_q    (base_q),
        .mode_q    (mode_q),
        .len_q     (len_q)
    );

    ring_addr_calc #(.AW(AW), .LW(LW)) u_addr (
        .base_q (base_q),
        .mode_q (mode_q),
        .idx    (idx_q),
        .addr   (entry_addr)
    );

    assign rewind    = load | len_wr | restart;
    assign idx_plus2 = {1'b0, idx_q} + (LW+1)'(2);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= POS_HEAD;
            idx_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            pos_q  <= pos_d;
            idx_q  <= idx_d;
            wrap_q <= wrap_d;
        end
    end

    // Next position, index and wrap
    always_comb begin
        pos_d  = pos_q;
        idx_d  = idx_q;
        wrap_d = 1'b0;
        if (rewind) begin
            pos_d = POS_HEAD;
            idx_d = '0;
        end else if (advance) begin
            unique case (pos_q)
                POS_HEAD: begin
                    if (len_q == LW'(1)) begin
                        wrap_d = 1'b1;
                    end else if (len_q == LW'(2)) begin
                        idx_d = LW'(1);
                        pos_d = POS_TAIL;
                    end else begin
                        idx_d = LW'(1);
                        pos_d = POS_BODY;
                    end
                end
                POS_BODY: begin
                    idx_d = idx_q + LW'(1);
                    pos_d = (idx_plus2 == {1'b0, len_q}) ? POS_TAIL : POS_BODY;
                end
                POS_TAIL: begin
                    idx_d  = '0;
                    pos_d  = POS_HEAD;
                    wrap_d = 1'b1;
                end
                default: begin
                    idx_d = '0;
                    pos_d = POS_HEAD;
                end
            endcase
        end
    end

    assign entry_idx  = idx_q;
    assign entry_wrap = wrap_q;
endmodule

// File: rtl/ring_desc_seq_chk.sv
module ring_desc_seq_chk #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load,
    input logic          len_wr,
    input logic          restart,
    input logic          advance,
    input logic          mode_q,
    input logic [LW-1:0] len_q,
    input logic [LW-1:0] entry_idx,
    input logic [AW-1:0] entry_addr,
    input logic          entry_wrap
);
    // R8: a wrap always lands on entry 0
    p_wrap_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        entry_wrap |-> (entry_idx == '0));

    // R8: a wrap pulse follows an advance
    p_wrap_after_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        entry_wrap |-> $past(advance));

    // R8: index stays inside the ring
    p_idx_in_ring_r8: assert property (@(posedge clk) disable iff (!rst_n)
        entry_idx < len_q);

    // R8: plain advance below the last entry increments
    p_adv_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && !len_wr && !restart &&
         ({1'b0, entry_idx} + (LW+1)'(1) != {1'b0, len_q}))
        |=> (entry_idx == $past(entry_idx) + LW'(1)) && !entry_wrap);

    // R9: rewinding commands return to entry 0 without wrap
    p_rewind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load || len_wr || restart) |=> (entry_idx == '0) && !entry_wrap);

    // R4: address alignment follows the loaded stride
    p_addr_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q ? (entry_addr[3:0] == 4'd0) : (entry_addr[2:0] == 3'd0));

    // R7: length never drops to zero
    p_len_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        len_q != '0);
endmodule

bind ring_desc_seq ring_desc_seq_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .len_wr     (len_wr),
    .restart    (restart),
    .advance    (advance),
    .mode_q     (mode_q),
    .len_q      (len_q),
    .entry_idx  (entry_idx),
    .entry_addr (entry_addr),
    .entry_wrap (entry_wrap)
);

// File: tb/sim_ring_desc_seq.sv
module sim_ring_desc_seq;
    localparam int AW = 32;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          mode32 = 1'b0;
    logic [3:0]    len_code = '0;
    logic          len_wr = 1'b0;
    logic [LW-1:0] len_val = '0;
    logic          restart = 1'b0;
    logic          advance = 1'b0;
    logic [LW-1:0] entry_idx;
    logic [AW-1:0] entry_addr;
    logic          entry_wrap;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ring_desc_seq #(.AW(AW), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .base_addr(base_addr),
        .mode32(mode32), .len_code(len_code), .len_wr(len_wr),
        .len_val(len_val), .restart(restart), .advance(advance),
        .entry_idx(entry_idx), .entry_addr(entry_addr), .entry_wrap(entry_wrap)
    );

    // Vector table: mode32, len_code, expected ring length
    localparam int NV = 12;
    localparam logic       V_MODE [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0};
    localparam logic [3:0] V_CODE [NV] = '{0, 3, 9, 10, 12, 15, 6, 0, 5, 7, 11, 15};
    localparam int         V_LEN  [NV] = '{1, 8, 512, 512, 512, 512, 64, 1, 32, 128, 8, 128};
    localparam string      V_REQ  [NV] = '{"R1", "R1", "R1", "R2", "R2", "R2", "R1",
                                           "R3", "R3", "R3", "R3", "R3"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Each command: drive at negedge, hold one clock, sample at following negedge
    task automatic do_load(input logic m, input logic [3:0] c, input logic [AW-1:0] b);
        mode32 = m; len_code = c; base_addr = b; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic do_len(input logic [LW-1:0] v);
        len_val = v; len_wr = 1'b1;
        @(negedge clk);
        len_wr = 1'b0;
    endtask

    task automatic do_adv();
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 idx", 32'(entry_idx), 0);
        check("R10 wrap", 32'(entry_wrap), 0);
        check("R10 addr", entry_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_adv();
        check("R10 one-entry ring wraps", 32'(entry_wrap), 1);

        // R1 R2 R3: walk each ring fully
        for (int v = 0; v < NV; v++) begin
            int early;
            early = 0;
            do_load(V_MODE[v], V_CODE[v], 32'h0);
            for (int k = 0; k < V_LEN[v] - 1; k++) begin
                do_adv();
                if (entry_wrap) early++;
            end
            check({V_REQ[v], " no early wrap"}, early, 0);
            check({V_REQ[v], " last idx"}, 32'(entry_idx), V_LEN[v] - 1);
            do_adv();
            check({V_REQ[v], " wrap at length"}, 32'(entry_wrap), 1);
            check({V_REQ[v], " idx after wrap"}, 32'(entry_idx), 0);
        end

        // R4 R5: stride and base mask, 32-bit mode
        do_load(1'b1, 4'd4, 32'h1000_0005);
        check("R5 base mask wide", entry_addr, 32'h1000_0000);
        repeat (3) do_adv();
        check("R4 stride 16", entry_addr, 32'h1000_0030);
        // R4 R5: 16-bit mode
        do_load(1'b0, 4'd4, 32'h2000_000F);
        check("R5 base mask narrow", entry_addr, 32'h2000_0008);
        repeat (5) do_adv();
        check("R4 stride 8", entry_addr, 32'h2000_0030);

        // R8: wrap is a single-cycle pulse
        do_load(1'b1, 4'd1, 32'h0);
        do_adv();
        do_adv();
        check("R8 wrap pulse", 32'(entry_wrap), 1);
        @(negedge clk);
        check("R8 wrap drops", 32'(entry_wrap), 0);

        // R6: explicit length 5 overrides code
        do_load(1'b1, 4'd9, 32'h0);
        do_len(16'd5);
        repeat (4) do_adv();
        check("R6 idx 4 no wrap", 32'(entry_wrap), 0);
        check("R6 idx", 32'(entry_idx), 4);
        do_adv();
        check("R6 wrap at 5", 32'(entry_wrap), 1);
        // R6: len_wr beats load in same cycle
        mode32 = 1'b1; len_code = 4'd9; load = 1'b1; len_val = 16'd3; len_wr = 1'b1;
        @(negedge clk);
        load = 1'b0; len_wr = 1'b0;
        repeat (3) do_adv();
        check("R6 len_wr priority", 32'(entry_wrap), 1);

        // R7: zero length acts as one entry
        do_len(16'd0);
        do_adv();
        check("R7 zero len wrap", 32'(entry_wrap), 1);
        do_adv();
        check("R7 zero len idx", 32'(entry_idx), 0);
        check("R7 zero len wrap again", 32'(entry_wrap), 1);

        // R9: restart, load and len_wr beat advance
        do_load(1'b1, 4'd3, 32'h0);
        repeat (3) do_adv();
        advance = 1'b1; restart = 1'b1;
        @(negedge clk);
        advance = 1'b0; restart = 1'b0;
        check("R9 restart idx", 32'(entry_idx), 0);
        check("R9 restart no wrap", 32'(entry_wrap), 0);
        repeat (7) do_adv();
        advance = 1'b1; load = 1'b1;
        @(negedge clk);
        advance = 1'b0; load = 1'b0;
        check("R9 load at tail idx", 32'(entry_idx), 0);
        check("R9 load at tail no wrap", 32'(entry_wrap), 0);
        repeat (2) do_adv();
        advance = 1'b1; len_val = 16'd20; len_wr = 1'b1;
        @(negedge clk);
        advance = 1'b0; len_wr = 1'b0;
        check("R9 len_wr idx", 32'(entry_idx), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule